// File: doc/BRIEF.md
# Register Indirect Address Generator

This block forms the operand effective address for a 16-bit load/store datapath with sixteen working registers. Each request carries a 3-bit addressing-mode code and a 5-bit operand field whose low four bits name a pointer register. The block reads that register through a simple read port in the request cycle. One clock later it presents the memory address, the modified pointer value with its write-back enable, and the memory read or write strobe. All of these appear on the same cycle.

Four of the modes change the pointer by a fixed stride of two, either before or after the access, and the new value wraps modulo 2^16. A register-direct mode only names a register and touches no memory. A short-literal form turns the operand field into an immediate. The indexed codes, which fall outside this block, are reported as illegal. When the pointer register holds an undefined value, the access is flagged unknown and any store through it is dropped. The pointer update still goes ahead.

Top module: `agu_indirect_top`

## Requirements
- R1: While reset is held, every enable output is 0 and every address, index and data output is 0.
- R2: Outputs reflect the request presented one clock earlier. A cycle with `req_valid` low yields all enables low and all value outputs 0. At most one of memory access, direct select, literal and illegal is active in a cycle.
- R3: Mode code 0 (register direct) raises `dir_sel` with `dir_idx` equal to field bits [3:0]. No memory strobe is raised and `ptr_we` stays low.
- R4: Mode code 1 (plain indirect) issues the access at the pointer register's value with `ptr_we` low.
- R5: Mode codes 2 (post-decrement) and 3 (post-increment) access at the old pointer. In the same cycle they write back old-2 or old+2 to the register named by field bits [3:0].
- R6: Mode codes 4 (pre-decrement) and 5 (pre-increment) compute old-2 or old+2, write it back and access memory at that new value.
- R7: Pointer arithmetic wraps modulo 2^16: 0xFFFF incremented gives 0x0001, and 0x0000 decremented gives 0xFFFE.
- R8: With `req_lit_form` = 1, mode codes 6 and 7 raise `lit_valid` with `lit_value` equal to the 5-bit field, zero-extended. There is no memory strobe and no pointer write.
- R9: With `req_lit_form` = 0, mode codes 6 and 7 (indexed forms) raise `illegal_mode` only. All other enables stay low and all value outputs stay 0.
- R10: If the pointer register is flagged undefined, a memory access raises `mem_unknown`. A store raises neither `mem_rd_en` nor `mem_wr_en`, while a load still raises `mem_rd_en`. A pointer update still occurs and is marked with `ptr_unknown`.
- R11: For an access mode, `req_write` = 1 selects `mem_wr_en` and `req_write` = 0 selects `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing-mode code |
| req_field | input | 5 | Operand field: register number in [3:0], immediate in [4:0] |
| req_write | input | 1 | Access is a store |
| req_lit_form | input | 1 | Codes 6/7 mean short literal (1) or indexed (0) |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read value |
| rf_rd_undef | input | 1 | Read value is undefined |
| mem_rd_en | output | 1 | Memory load strobe |
| mem_wr_en | output | 1 | Memory store strobe |
| mem_addr | output | 16 | Effective memory address |
| mem_unknown | output | 1 | Address came from an undefined pointer |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_idx | output | 4 | Pointer write-back register |
| ptr_data | output | 16 | Modified pointer value |
| ptr_unknown | output | 1 | Written pointer is still undefined |
| dir_sel | output | 1 | Register-direct operand selected |
| dir_idx | output | 4 | Register-direct index |
| lit_valid | output | 1 | Immediate operand present |
| lit_value | output | 16 | Zero-extended immediate |
| illegal_mode | output | 1 | Unsupported mode code requested |

## Verification
Repeated post-increments on one register, with the model's write-back applied, show that the stride is accumulated and not re-read from a stale value. Matching pre- and post-modify pairs on the same register separate access-before-update from update-before-access. Pointers at 0xFFFF and 0x0000 expose a missing wrap. Codes 6 and 7 are tried under both settings of the literal-form input, which separates the literal and illegal paths. Loads and stores through an undefined register show that the store is dropped while the pointer update survives. A long random stream of mixed modes then compares every output bit on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;

   localparam int AGU_MODE_W = 3;

   typedef enum logic [AGU_MODE_W-1:0] {
      AM_DIRECT   = 3'd0,
      AM_IND      = 3'd1,
      AM_POST_DEC = 3'd2,
      AM_POST_INC = 3'd3,
      AM_PRE_DEC  = 3'd4,
      AM_PRE_INC  = 3'd5,
      AM_SHORT_A  = 3'd6,
      AM_SHORT_B  = 3'd7
   } agu_mode_e;

   typedef struct packed {
      logic direct;   // register operand, no memory
      logic access;   // memory access through pointer
      logic modify;   // pointer is written back
      logic pre;      // modify before access
      logic inc;      // step up (else down)
      logic lit;      // immediate operand
      logic bad;      // unsupported code
   } agu_dec_t;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
   import agu_pkg::*;
(
   input  logic                  valid,
   input  logic [AGU_MODE_W-1:0] mode,
   input  logic                  lit_form,
   output agu_dec_t              dec
);

   always_comb begin
      dec = '0;
      if (valid) begin
         case (agu_mode_e'(mode))
            AM_DIRECT:   dec.direct = 1'b1;
            AM_IND:      dec.access = 1'b1;
            AM_POST_DEC: begin
               dec.access = 1'b1;
               dec.modify = 1'b1;
            end
            AM_POST_INC: begin
               dec.access = 1'b1;
               dec.modify = 1'b1;
               dec.inc    = 1'b1;
            end
            AM_PRE_DEC: begin
               dec.access = 1'b1;
               dec.modify = 1'b1;
               dec.pre    = 1'b1;
            end
            AM_PRE_INC: begin
               dec.access = 1'b1;
               dec.modify = 1'b1;
               dec.pre    = 1'b1;
               dec.inc    = 1'b1;
            end
            default: begin
               if (lit_form) dec.lit = 1'b1;
               else          dec.bad = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/agu_ptr_math.sv
module agu_ptr_math
   import agu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STRIDE = 2
) (
   input  logic [DATA_W-1:0] ptr,
   input  agu_dec_t          dec,
   output logic [DATA_W-1:0] next_ptr,
   output logic [DATA_W-1:0] eff_addr
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(STRIDE);

   generate
      if (STRIDE < 1 || STRIDE > 64) begin : g_bad_stride
         $error("agu_ptr_math: STRIDE out of range");
      end
   endgenerate

   logic [DATA_W-1:0] up_val;
   logic [DATA_W-1:0] dn_val;

   // Both directions computed in parallel; modulo wrap comes from width.
   assign up_val   = ptr + STEP;
   assign dn_val   = ptr - STEP;
   assign next_ptr = dec.inc ? up_val : dn_val;
   assign eff_addr = dec.pre ? next_ptr : ptr;

endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage
   import agu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int IDX_W      = 4,
   parameter int LIT_W      = 5,
   parameter int FIELD_W    = 5,
   parameter bit LIT_SIGNED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  agu_dec_t           dec,
   input  logic [FIELD_W-1:0] field,
   input  logic               is_write,
   input  logic               ptr_undef,
   input  logic [DATA_W-1:0]  next_ptr,
   input  logic [DATA_W-1:0]  eff_addr,
   output logic               mem_rd_en,
   output logic               mem_wr_en,
   output logic [DATA_W-1:0]  mem_addr,
   output logic               mem_unknown,
   output logic               ptr_we,
   output logic [IDX_W-1:0]   ptr_idx,
   output logic [DATA_W-1:0]  ptr_data,
   output logic               ptr_unknown,
   output logic               dir_sel,
   output logic [IDX_W-1:0]   dir_idx,
   output logic               lit_valid,
   output logic [DATA_W-1:0]  lit_value,
   output logic               illegal_mode
);

   logic [DATA_W-1:0] lit_ext;
   logic [IDX_W-1:0]  reg_num;

   assign reg_num = field[IDX_W-1:0];

   generate
      if (LIT_W >= DATA_W) begin : g_bad_lit
         $error("agu_out_stage: LIT_W must be narrower than DATA_W");
      end
      if (LIT_SIGNED) begin : g_lit_sext
         assign lit_ext = {{(DATA_W-LIT_W){field[LIT_W-1]}}, field[LIT_W-1:0]};
      end else begin : g_lit_zext
         assign lit_ext = {{(DATA_W-LIT_W){1'b0}}, field[LIT_W-1:0]};
      end
   endgenerate

   logic              n_rd, n_wr, n_unk, n_we, n_punk, n_dir, n_lit, n_bad;
   logic [DATA_W-1:0] n_addr, n_pdata, n_lval;
   logic [IDX_W-1:0]  n_pidx, n_didx;

   always_comb begin
      n_rd    = dec.access & ~is_write;
      n_wr    = dec.access & is_write & ~ptr_undef;
      n_unk   = dec.access & ptr_undef;
      n_addr  = dec.access ? eff_addr : '0;
      n_we    = dec.modify;
      n_pidx  = dec.modify ? reg_num : '0;
      n_pdata = dec.modify ? next_ptr : '0;
      n_punk  = dec.modify & ptr_undef;
      n_dir   = dec.direct;
      n_didx  = dec.direct ? reg_num : '0;
      n_lit   = dec.lit;
      n_lval  = dec.lit ? lit_ext : '0;
      n_bad   = dec.bad;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_rd_en    <= 1'b0;
         mem_wr_en    <= 1'b0;
         mem_addr     <= '0;
         mem_unknown  <= 1'b0;
         ptr_we       <= 1'b0;
         ptr_idx      <= '0;
         ptr_data     <= '0;
         ptr_unknown  <= 1'b0;
         dir_sel      <= 1'b0;
         dir_idx      <= '0;
         lit_valid    <= 1'b0;
         lit_value    <= '0;
         illegal_mode <= 1'b0;
      end else begin
         mem_rd_en    <= n_rd;
         mem_wr_en    <= n_wr;
         mem_addr     <= n_addr;
         mem_unknown  <= n_unk;
         ptr_we       <= n_we;
         ptr_idx      <= n_pidx;
         ptr_data     <= n_pdata;
         ptr_unknown  <= n_punk;
         dir_sel      <= n_dir;
         dir_idx      <= n_didx;
         lit_valid    <= n_lit;
         lit_value    <= n_lval;
         illegal_mode <= n_bad;
      end
   end

endmodule

// File: rtl/agu_indirect_top.sv
module agu_indirect_top
   import agu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int REG_CNT    = 16,
   parameter int STRIDE     = 2,
   parameter int LIT_W      = 5,
   parameter bit LIT_SIGNED = 1'b0,
   localparam int IDX_W     = $clog2(REG_CNT),
   localparam int FIELD_W   = (LIT_W > IDX_W) ? LIT_W : IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [AGU_MODE_W-1:0] req_mode,
   input  logic [FIELD_W-1:0]    req_field,
   input  logic                  req_write,
   input  logic                  req_lit_form,
   output logic [IDX_W-1:0]      rf_rd_idx,
   input  logic [DATA_W-1:0]     rf_rd_data,
   input  logic                  rf_rd_undef,
   output logic                  mem_rd_en,
   output logic                  mem_wr_en,
   output logic [DATA_W-1:0]     mem_addr,
   output logic                  mem_unknown,
   output logic                  ptr_we,
   output logic [IDX_W-1:0]      ptr_idx,
   output logic [DATA_W-1:0]     ptr_data,
   output logic                  ptr_unknown,
   output logic                  dir_sel,
   output logic [IDX_W-1:0]      dir_idx,
   output logic                  lit_valid,
   output logic [DATA_W-1:0]     lit_value,
   output logic                  illegal_mode
);

   generate
      if (REG_CNT < 2 || (1 << IDX_W) != REG_CNT) begin : g_bad_regs
         $error("agu_indirect_top: REG_CNT must be a power of two");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("agu_indirect_top: DATA_W too small");
      end
   endgenerate

   agu_dec_t          dec;
   logic [DATA_W-1:0] next_ptr;
   logic [DATA_W-1:0] eff_addr;

   assign rf_rd_idx = req_field[IDX_W-1:0];

   agu_mode_decode i_dec (
      .valid    (req_valid),
      .mode     (req_mode),
      .lit_form (req_lit_form),
      .dec      (dec)
   );

   agu_ptr_math #(
      .DATA_W (DATA_W),
      .STRIDE (STRIDE)
   ) i_math (
      .ptr      (rf_rd_data),
      .dec      (dec),
      .next_ptr (next_ptr),
      .eff_addr (eff_addr)
   );

   agu_out_stage #(
      .DATA_W     (DATA_W),
      .IDX_W      (IDX_W),
      .LIT_W      (LIT_W),
      .FIELD_W    (FIELD_W),
      .LIT_SIGNED (LIT_SIGNED)
   ) i_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .dec          (dec),
      .field        (req_field),
      .is_write     (req_write),
      .ptr_undef    (rf_rd_undef),
      .next_ptr     (next_ptr),
      .eff_addr     (eff_addr),
      .mem_rd_en    (mem_rd_en),
      .mem_wr_en    (mem_wr_en),
      .mem_addr     (mem_addr),
      .mem_unknown  (mem_unknown),
      .ptr_we       (ptr_we),
      .ptr_idx      (ptr_idx),
      .ptr_data     (ptr_data),
      .ptr_unknown  (ptr_unknown),
      .dir_sel      (dir_sel),
      .dir_idx      (dir_idx),
      .lit_valid    (lit_valid),
      .lit_value    (lit_value),
      .illegal_mode (illegal_mode)
   );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
   parameter int DATA_W  = 16,
   parameter int IDX_W   = 4,
   parameter int FIELD_W = 5,
   parameter int LIT_W   = 5,
   parameter int STRIDE  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [2:0]         req_mode,
   input logic [FIELD_W-1:0] req_field,
   input logic               req_write,
   input logic               req_lit_form,
   input logic [IDX_W-1:0]   rf_rd_idx,
   input logic [DATA_W-1:0]  rf_rd_data,
   input logic               rf_rd_undef,
   input logic               mem_rd_en,
   input logic               mem_wr_en,
   input logic [DATA_W-1:0]  mem_addr,
   input logic               mem_unknown,
   input logic               ptr_we,
   input logic [IDX_W-1:0]   ptr_idx,
   input logic [DATA_W-1:0]  ptr_data,
   input logic               ptr_unknown,
   input logic               dir_sel,
   input logic [IDX_W-1:0]   dir_idx,
   input logic               lit_valid,
   input logic [DATA_W-1:0]  lit_value,
   input logic               illegal_mode
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(STRIDE);

   logic [DATA_W-1:0] rd_plus;
   logic [DATA_W-1:0] rd_minus;
   logic              any_mem;

   assign rd_plus  = rf_rd_data + STEP;
   assign rd_minus = rf_rd_data - STEP;
   assign any_mem  = mem_rd_en | mem_wr_en;

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(any_mem | ptr_we | dir_sel | lit_valid | illegal_mode));

   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({any_mem | mem_unknown, dir_sel, lit_valid, illegal_mode}));

   assert_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd0) |=>
         (dir_sel && dir_idx == $past(req_field[IDX_W-1:0]) && !ptr_we && !any_mem));

   assert_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd1) |=> (!ptr_we && mem_addr == $past(rf_rd_data)));

   assert_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd3) |=>
         (ptr_we && mem_addr == $past(rf_rd_data) && ptr_data == $past(rd_plus)));

   assert_predec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd4) |=>
         (ptr_we && ptr_data == $past(rd_minus) && mem_addr == ptr_data));

   assert_wb_with_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_we |-> (any_mem || mem_unknown));

   assert_literal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lit_valid |-> (lit_value[DATA_W-1:LIT_W] == '0 && !ptr_we && !any_mem));

   assert_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_lit_form && req_mode[2:1] == 2'b11) |=>
         (illegal_mode && !ptr_we && !any_mem && !lit_valid && !dir_sel));

   assert_nostore_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_unknown |-> !mem_wr_en);

   assert_rw_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));

endmodule

bind agu_indirect_top agu_checker #(
   .DATA_W  (DATA_W),
   .IDX_W   (IDX_W),
   .FIELD_W (FIELD_W),
   .LIT_W   (LIT_W),
   .STRIDE  (STRIDE)
) i_agu_chk (.*);

// File: tb/test_agu_indirect_top.sv
`timescale 1ns/1ps
module test_agu_indirect_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic [4:0]  req_field = '0;
   logic        req_write = 1'b0;
   logic        req_lit_form = 1'b0;
   logic [3:0]  rf_rd_idx;
   logic [15:0] rf_rd_data;
   logic        rf_rd_undef;
   logic        mem_rd_en, mem_wr_en, mem_unknown, ptr_we, ptr_unknown;
   logic        dir_sel, lit_valid, illegal_mode;
   logic [15:0] mem_addr, ptr_data, lit_value;
   logic [3:0]  ptr_idx, dir_idx;

   logic [15:0] rf   [16];
   logic        rf_u [16];

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   assign rf_rd_data  = rf[rf_rd_idx];
   assign rf_rd_undef = rf_u[rf_rd_idx];

   agu_indirect_top i_agu_indirect_top (
      .clk, .rst_n, .req_valid, .req_mode, .req_field, .req_write, .req_lit_form,
      .rf_rd_idx, .rf_rd_data, .rf_rd_undef,
      .mem_rd_en, .mem_wr_en, .mem_addr, .mem_unknown,
      .ptr_we, .ptr_idx, .ptr_data, .ptr_unknown,
      .dir_sel, .dir_idx, .lit_valid, .lit_value, .illegal_mode
   );

   logic [63:0] act;
   assign act = {mem_rd_en, mem_wr_en, mem_addr, mem_unknown, ptr_we, ptr_idx,
                 ptr_data, ptr_unknown, dir_sel, dir_idx, lit_valid, lit_value,
                 illegal_mode};

   // expected outputs of the request in flight
   logic [63:0] exp_vec = '0;
   logic        exp_we = 1'b0;
   logic [3:0]  exp_idx = '0;
   logic [15:0] exp_data = '0;
   string       exp_tag = "R2";

   task automatic check(input string tag, input logic [63:0] a, input logic [63:0] e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, a, e);
      end
   endtask

   function automatic string tag_of(input logic v, input logic [2:0] m,
                                    input logic lf, input logic u, input logic w);
      if (!v) return "R2";
      if (m == 3'd0) return "R3";
      if (m >= 3'd6) return lf ? "R8" : "R9";
      if (u) return "R10";
      if (w) return "R11";
      if (m == 3'd1) return "R4";
      if (m <= 3'd3) return "R5";
      return "R6";
   endfunction

   // Compare the previous request, retire its pointer write, issue the next.
   task automatic step(input logic v, input logic [2:0] m, input logic [4:0] f,
                       input logic w, input logic lf, input string tag);
      logic [15:0] p, nx, ad, lv;
      logic        u, rd, wr, unk, we, punk, dsel, lit, bad, acc;
      logic [3:0]  pidx, didx;
      @(negedge clk);
      check(exp_tag, act, exp_vec);
      if (exp_we) rf[exp_idx] = exp_data;
      p = rf[f[3:0]];
      u = rf_u[f[3:0]];
      {rd, wr, unk, we, punk, dsel, lit, bad, acc} = '0;
      nx = '0; ad = '0; lv = '0; pidx = '0; didx = '0;
      if (v) begin
         case (m)
            3'd0: begin dsel = 1'b1; didx = f[3:0]; end
            3'd1: begin acc = 1'b1; ad = p; end
            3'd2: begin acc = 1'b1; we = 1'b1; nx = p - 16'd2; ad = p; end
            3'd3: begin acc = 1'b1; we = 1'b1; nx = p + 16'd2; ad = p; end
            3'd4: begin acc = 1'b1; we = 1'b1; nx = p - 16'd2; ad = nx; end
            3'd5: begin acc = 1'b1; we = 1'b1; nx = p + 16'd2; ad = nx; end
            default: begin
               if (lf) begin lit = 1'b1; lv = {11'd0, f}; end
               else bad = 1'b1;
            end
         endcase
      end
      if (acc) begin
         rd  = !w;
         wr  = w && !u;
         unk = u;
      end
      if (we) begin
         pidx = f[3:0];
         punk = u;
      end
      exp_vec  = {rd, wr, ad, unk, we, pidx, nx, punk, dsel, didx, lit, lv, bad};
      exp_we   = we;
      exp_idx  = f[3:0];
      exp_data = nx;
      exp_tag  = (tag == "") ? tag_of(v, m, lf, u, w) : tag;
      req_valid    = v;
      req_mode     = m;
      req_field    = f;
      req_write    = w;
      req_lit_form = lf;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         rf[i]   = 16'h1000 + 16'(i * 32);
         rf_u[i] = 1'b0;
      end
      rf[3]   = 16'hFFFF;
      rf[4]   = 16'h0000;
      rf_u[9] = 1'b1;

      repeat (3) @(negedge clk);
      check("R1", act, 64'd0);          // reset state
      rst_n = 1'b1;

      step(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, "R2");
      step(1'b1, 3'd0, 5'd2, 1'b0, 1'b0, "R3");
      step(1'b1, 3'd1, 5'd1, 1'b0, 1'b0, "R4");
      step(1'b1, 3'd1, 5'd1, 1'b1, 1'b0, "R11");
      step(1'b1, 3'd3, 5'd5, 1'b0, 1'b0, "R5");
      step(1'b1, 3'd3, 5'd5, 1'b0, 1'b0, "R5");
      step(1'b1, 3'd2, 5'd5, 1'b0, 1'b0, "R5");
      step(1'b1, 3'd5, 5'd6, 1'b0, 1'b0, "R6");
      step(1'b1, 3'd4, 5'd6, 1'b0, 1'b0, "R6");
      step(1'b1, 3'd3, 5'd3, 1'b0, 1'b0, "R7");
      step(1'b1, 3'd4, 5'd4, 1'b0, 1'b0, "R7");
      step(1'b1, 3'd6, 5'h1F, 1'b0, 1'b1, "R8");
      step(1'b1, 3'd7, 5'h0A, 1'b0, 1'b1, "R8");
      step(1'b1, 3'd6, 5'd7, 1'b0, 1'b0, "R9");
      step(1'b1, 3'd7, 5'd7, 1'b1, 1'b0, "R9");
      step(1'b1, 3'd1, 5'd7, 1'b0, 1'b0, "R9");   // register 7 still intact
      step(1'b1, 3'd3, 5'd9, 1'b0, 1'b0, "R10");
      step(1'b1, 3'd5, 5'd9, 1'b1, 1'b0, "R10");
      step(1'b1, 3'd1, 5'd9, 1'b1, 1'b0, "R10");
      step(1'b1, 3'd3, 5'd8, 1'b1, 1'b0, "R11");
      step(1'b0, 3'd3, 5'd8, 1'b1, 1'b0, "R2");

      for (int n = 0; n < 400; n++) begin
         step(1'($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
              5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), "");
      end
      step(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, "R2");
      step(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, "R2");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule